// File: doc/BRIEF.md
# Supply-Aware Memory Access Guard

This block sits between a memory controller and a nonvolatile memory. It watches two digital supply-status flags and decides when the memory may be touched. One flag says the rail is above the write-inhibit threshold. The other says the rail is above the minimum operating voltage. Until the rail has been good for a full startup interval, the guard forces the memory's active-low chip enable and write enable to their inactive (high) level. Any access request made during that time is refused.

Both flags are resynchronised by two-flop chains. A three-state sequencer then walks through inhibit, startup and normal operation. The startup hold is timed by a counter whose length is derived from the clock frequency and the hold time given as parameters. With the defaults, 50 MHz and 2000 us, the hold is 100,000 cycles. A brownout sends the sequencer back to inhibit. Every return to service repeats the whole startup hold. Ready is high only in normal operation, and only then do the user's strobes reach the memory.

Top module: `pwrseq_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ready` is 0, `mem_ce_n` and `mem_we_n` are 1 and `req_refused` is 0.
- R2: Each supply flag passes through two synchroniser flops. A change at an input pin takes effect in the sequencer on the third rising edge after it is applied.
- R3: Once both synchronised flags are 1, the sequencer spends exactly STARTUP_CYCLES = CLK_HZ/1_000_000*STARTUP_US cycles in startup. `ready` rises on the edge after that, and only from startup. The hold counter never passes STARTUP_CYCLES-1.
- R4: Whenever `ready` is 0, `mem_ce_n` and `mem_we_n` are 1, whatever `usr_ce_n` and `usr_we_n` carry.
- R5: Whenever `ready` is 1, `mem_ce_n` equals `usr_ce_n` and `mem_we_n` equals `usr_we_n` in the same cycle.
- R6: A synchronised `sup_above_wi` of 0 sends the sequencer to inhibit from any state. `ready` drops on the third edge after the pin falls.
- R7: If the synchronised `sup_above_min` falls during startup, the sequencer returns to inhibit. A later rise restarts the full hold from zero.
- R8: While in normal operation with `sup_above_wi` at 1, a fall of `sup_above_min` alone leaves `ready` at 1.
- R9: A `usr_req` sampled while `ready` is 0 gives a one-cycle `req_refused` pulse on the next cycle. A request while `ready` is 1 gives no pulse.
- R10: With `sup_above_wi` at 1 and `sup_above_min` at 0, the sequencer stays in inhibit and `ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_wi | input | 1 | Asynchronous flag: rail above write-inhibit threshold |
| sup_above_min | input | 1 | Asynchronous flag: rail above minimum operating voltage |
| usr_req | input | 1 | User access request strobe |
| usr_ce_n | input | 1 | User chip enable, active low |
| usr_we_n | input | 1 | User write enable, active low |
| mem_ce_n | output | 1 | Chip enable to memory, active low, forced high when not ready |
| mem_we_n | output | 1 | Write enable to memory, active low, forced high when not ready |
| ready | output | 1 | High only in normal operation |
| req_refused | output | 1 | One-cycle pulse: a request was made while not ready |

## Verification
A sequencer stuck in or wrongly leaving a state shows at `ready` and the memory strobes. The bench checks these on the exact cycle that the three-edge synchroniser latency and the hold length predict. An off-by-one in the hold counter, or a count that is not restarted after an aborted startup, moves the rise of `ready` by a cycle. That shift is caught on the cycle where the rise is expected. A brownout path that fails to reach inhibit leaves the strobes live three cycles after the flag falls.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PS_INHIBIT = 2'd0,
        PS_STARTUP = 2'd1,
        PS_NORMAL  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic above_wi;
        logic above_min;
    } sup_flags_t;

    function automatic longint startup_cycles(input longint clk_hz, input longint hold_us);
        return (clk_hz / 64'd1_000_000) * hold_us;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter longint CLK_HZ     = 50_000_000,
    parameter longint STARTUP_US = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  sup_flags_t flags_i,
    output logic       ready_o
);
    localparam longint CYCLES = startup_cycles(CLK_HZ, STARTUP_US);
    localparam int     CNT_W  = $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    pwr_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        case (state)
            PS_INHIBIT: if (flags_i.above_wi && flags_i.above_min) nxt = PS_STARTUP;
            PS_STARTUP: begin
                if (!flags_i.above_wi || !flags_i.above_min) nxt = PS_INHIBIT;
                else if (cnt == LAST)                        nxt = PS_NORMAL;
            end
            PS_NORMAL:  if (!flags_i.above_wi) nxt = PS_INHIBIT;
            default:    nxt = PS_INHIBIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_INHIBIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PS_STARTUP && nxt == PS_STARTUP)
                cnt <= (cnt == LAST) ? cnt : cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    assign ready_o = (state == PS_NORMAL);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    assert_normal_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PS_NORMAL && $past(state) != PS_NORMAL) |-> $past(state) == PS_STARTUP);
    assert_brownout_R6: assert property (@(posedge clk) disable iff (rst)
        !flags_i.above_wi |=> state == PS_INHIBIT);
    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PS_STARTUP && !flags_i.above_min) |=> (state == PS_INHIBIT && cnt == '0));
    assert_hold_min_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PS_NORMAL && flags_i.above_wi) |=> state == PS_NORMAL);
endmodule

// File: rtl/pwrseq_gate.sv
module pwrseq_gate (
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    input  logic usr_req,
    input  logic usr_ce_n,
    input  logic usr_we_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic req_refused
);
    assign mem_ce_n = ready_i ? usr_ce_n : 1'b1;
    assign mem_we_n = ready_i ? usr_we_n : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) req_refused <= 1'b0;
        else     req_refused <= usr_req && !ready_i;
    end

    assert_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        (usr_req && !ready_i) |=> req_refused);
    assert_no_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        (!usr_req || ready_i) |=> !req_refused);
    assert_strobes_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !ready_i |-> (mem_ce_n && mem_we_n));
endmodule

// File: rtl/pwrseq_guard.sv
module pwrseq_guard
    import pwrseq_pkg::*;
#(
    parameter longint CLK_HZ     = 50_000_000,
    parameter longint STARTUP_US = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_above_wi,
    input  logic sup_above_min,
    input  logic usr_req,
    input  logic usr_ce_n,
    input  logic usr_we_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic ready,
    output logic req_refused
);
    sup_flags_t raw, synced;

    assign raw.above_wi  = sup_above_wi;
    assign raw.above_min = sup_above_min;

    pwrseq_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    pwrseq_fsm #(.CLK_HZ(CLK_HZ), .STARTUP_US(STARTUP_US)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .flags_i (synced),
        .ready_o (ready)
    );

    pwrseq_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .ready_i     (ready),
        .usr_req     (usr_req),
        .usr_ce_n    (usr_ce_n),
        .usr_we_n    (usr_we_n),
        .mem_ce_n    (mem_ce_n),
        .mem_we_n    (mem_we_n),
        .req_refused (req_refused)
    );
endmodule

// File: tb/tb_pwrseq_guard.sv
module tb_pwrseq_guard;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_above_wi = 1'b0, sup_above_min = 1'b0;
    logic usr_req = 1'b0, usr_ce_n = 1'b0, usr_we_n = 1'b0;
    logic mem_ce_n, mem_we_n, ready, req_refused;

    pwrseq_guard #(.CLK_HZ(1_000_000), .STARTUP_US(N)) dut (
        .clk(clk), .rst(rst), .sup_above_wi(sup_above_wi), .sup_above_min(sup_above_min),
        .usr_req(usr_req), .usr_ce_n(usr_ce_n), .usr_we_n(usr_we_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .ready(ready), .req_refused(req_refused)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    cyc;
        logic  rdy;
        logic  ce;
        logic  we;
        logic  refd;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0, reported = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int dc, input logic r, input logic c, input logic w,
                        input logic f, input string tag);
        exp_t e;
        e.cyc = cyc + dc; e.rdy = r; e.ce = c; e.we = w; e.refd = f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares queued expectations on their cycle, 1 ns after the falling edge.
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (e.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d seen at %0d", e.tag, e.cyc, cyc);
            end else if ({ready, mem_ce_n, mem_we_n, req_refused} !== {e.rdy, e.ce, e.we, e.refd}) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got rdy/ce/we/ref=%b%b%b%b exp %b%b%b%b", e.tag, cyc,
                         ready, mem_ce_n, mem_we_n, req_refused, e.rdy, e.ce, e.we, e.refd);
            end
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run hung, got not done exp done");
        end
        summary();
    end

    initial begin
        step(3);
        // R1: reset state, user strobes driven active
        push(0, 0, 1, 1, 0, "R1 in reset");
        step(1);
        rst = 1'b0;
        push(0, 0, 1, 1, 0, "R1 after reset");
        step(1);
        // R9 and R4: request while inhibited
        usr_req = 1'b1;
        push(0, 0, 1, 1, 0, "R4 strobes held");
        push(1, 0, 1, 1, 1, "R9 refused pulse");
        step(1);
        usr_req = 1'b0;
        push(1, 0, 1, 1, 0, "R9 pulse one cycle");
        step(1);
        // R10: only above write-inhibit
        sup_above_wi = 1'b1;
        push(30, 0, 1, 1, 0, "R10 stays inhibited");
        step(40);
        // R3 and R2: startup hold length
        sup_above_min = 1'b1;
        push(2 + N, 0, 1, 1, 0, "R3 not ready before hold ends");
        push(3 + N, 1, 0, 0, 0, "R3 ready after hold");
        step(N + 5);
        // R5: strobes pass through
        usr_we_n = 1'b1;
        push(0, 1, 0, 1, 0, "R5 we_n follows");
        step(1);
        usr_we_n = 1'b0;
        usr_ce_n = 1'b1;
        push(0, 1, 1, 0, 0, "R5 ce_n follows");
        step(1);
        usr_ce_n = 1'b0;
        usr_req = 1'b1;
        push(1, 1, 0, 0, 0, "R9 no pulse when ready");
        step(1);
        usr_req = 1'b0;
        step(1);
        // R8: min flag alone falls
        sup_above_min = 1'b0;
        push(5, 1, 0, 0, 0, "R8 stays ready");
        step(6);
        // R6 and R2: brownout latency
        sup_above_wi = 1'b0;
        push(2, 1, 0, 0, 0, "R2 two edges no effect");
        push(3, 0, 1, 1, 0, "R6 inhibit on brownout");
        step(5);
        // R3 recovery: full hold again
        sup_above_wi = 1'b1;
        sup_above_min = 1'b1;
        push(2 + N, 0, 1, 1, 0, "R3 recovery not early");
        push(3 + N, 1, 0, 0, 0, "R3 recovery ready");
        step(N + 5);
        // R7: abort during startup
        sup_above_wi = 1'b0;
        sup_above_min = 1'b0;
        step(5);
        sup_above_wi = 1'b1;
        sup_above_min = 1'b1;
        step(6);
        sup_above_min = 1'b0;
        push(N - 3, 0, 1, 1, 0, "R7 no ready at original time");
        push(N + 4, 0, 1, 1, 0, "R7 hold restarted");
        push(N + 5, 1, 0, 0, 0, "R7 ready after full restart");
        step(2);
        sup_above_min = 1'b1;
        step(N + 8);
        wait (q.size() == 0);
        step(1);
        done = 1'b1;
        summary();
    end
endmodule